// File: doc/BRIEF.md
# Modem Adapter Host Register Interface

This block is the byte-wide host-facing register set of a serial modem adapter. The host selects one of four ports with two address bits and uses single-cycle read and write strobes. Through these ports it sets the character format, sends and receives data bytes, reads a status byte of handshake and error flags, and loads the rate register. A read of the mask port copies the rate register into the interrupt mask.

On the line side, whole bytes move through a transmit valid/ready pair, a transmit-completion strobe and a receive valid strobe. Separate error strobes from the receive serializer set the error flags. The format fields, the rate value and the interrupt mask go out as plain outputs to the serializer and timer blocks next to this one.

The transmit path is a three-state machine. `TX_IDLE` holds no byte and the empty flags are clear, which is the reset state. `TX_HELD` holds a byte that is offered to the line. `TX_EMPTY` means the line reported completion and both empty flags are set. The transitions are:
- Host data write: any state to `TX_HELD`.
- Line handshake (`tx_valid && tx_ready`): `TX_HELD` to `TX_IDLE`.
- Completion (`tx_done`): `TX_IDLE` to `TX_EMPTY`.

The receive path has two states. `RX_VACANT` goes to `RX_LOADED` when a byte is accepted. `RX_LOADED` goes back to `RX_VACANT` when the host reads the data port.

Top module: `mdm_host_regs`

## Requirements
- R1: After reset the status byte reads 0x00, every format field, `rate_val` and `int_mask` are zero, and `tx_valid` is low.
- R2: A write to port 0 sets the format fields on the next cycle. Bits 3:2 go to `cfg_len` (00=5, 01=6, 10=7, 11=8 data bits). Bits 5:4 go to `cfg_par` (00 odd, 01 none, 10 even). Bit 6 goes to `cfg_stop2` (1 = two stop bits).
- R3: A read of port 0 returns the status byte. Bit 0 is transmit buffer empty, bit 1 is data available, bit 2 is serializer empty, bit 3 is parity error, bit 4 is overrun and bit 5 is framing error. Bits 7:6 are zero.
- R4: A write to port 1 puts the byte on `tx_data` with `tx_valid` high from the next cycle, and clears status bits 0 and 2.
- R5: A write to port 1 while a byte is still held replaces the held byte, and `tx_valid` stays high.
- R6: A cycle with `tx_valid` and `tx_ready` both high drops `tx_valid` on the next cycle. After that, `tx_done` sets status bits 0 and 2 together. `tx_done` has no effect while a byte is held.
- R7: `rx_valid` while data available is clear stores `rx_data`, sets status bit 1 and clears bits 5:3. While data available is set, `rx_valid` is ignored.
- R8: A pulse on `rx_err[0]`, `rx_err[1]` or `rx_err[2]` sets status bit 3, 4 or 5 respectively. A read of port 1 returns the stored byte and clears status bits 1, 3, 4 and 5.
- R9: A write to port 2 loads `rate_val`. A read of port 3 copies `rate_val` into `int_mask` on the next cycle.
- R10: Reads of port 2 and port 3 return 0x00.
- R11: Changing the address without a read or write strobe changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 2 | Port select |
| host_wr | input | 1 | Single-cycle write strobe |
| host_rd | input | 1 | Single-cycle read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the addressed port |
| cfg_len | output | 2 | Data length code |
| cfg_par | output | 2 | Parity code |
| cfg_stop2 | output | 1 | Two stop bits selected |
| rate_val | output | 8 | Rate register |
| int_mask | output | 8 | Interrupt mask |
| tx_data | output | 8 | Held transmit byte |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Line accepts the offered byte |
| tx_done | input | 1 | Line reports transmission complete |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_err | input | 3 | Parity, overrun, framing error strobes |

## Verification
If the transmit machine is in the wrong state, it shows within one cycle: `tx_valid` is wrong, or status bits 0 and 2 are wrong on the next port 0 read. A receive state that fails to clear loses the next incoming byte, so the following data port read returns stale data. Error flags that set or clear wrongly show in status bits 5:3 on the first status read after the strobe. A missed copy into the mask shows on `int_mask` one cycle after the port 3 read.

// File: rtl/mdm_host_pkg.sv
package mdm_host_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int ERR_W  = 3;

    typedef enum logic [ADDR_W-1:0] {
        PORT_CTRL = 2'd0,
        PORT_DATA = 2'd1,
        PORT_RATE = 2'd2,
        PORT_MASK = 2'd3
    } port_e;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_HELD  = 2'd1,
        TX_EMPTY = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_VACANT = 1'b0,
        RX_LOADED = 1'b1
    } rx_state_e;
endpackage

// File: rtl/mdm_tx_ctrl.sv
module mdm_tx_ctrl
    import mdm_host_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         tx_ready,
    input  logic         tx_done,
    output logic [W-1:0] tx_data,
    output logic         tx_valid,
    output logic         empty
);
    tx_state_e    state_q, state_n;
    logic [W-1:0] byte_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            byte_q  <= '0;
        end else begin
            state_q <= state_n;
            if (load) byte_q <= load_data;
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            TX_IDLE:  if (load) state_n = TX_HELD;
                      else if (tx_done) state_n = TX_EMPTY;
            TX_HELD:  if (load) state_n = TX_HELD;
                      else if (tx_ready) state_n = TX_IDLE;
            TX_EMPTY: if (load) state_n = TX_HELD;
            default:  state_n = TX_IDLE;
        endcase
    end

    always_comb begin
        tx_data  = byte_q;
        tx_valid = (state_q == TX_HELD);
        empty    = (state_q == TX_EMPTY);
    end
endmodule

// File: rtl/mdm_rx_ctrl.sv
module mdm_rx_ctrl
    import mdm_host_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int EW = ERR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [W-1:0]  rx_data,
    input  logic [EW-1:0] rx_err,
    input  logic          take,
    output logic [W-1:0]  rx_byte,
    output logic          avail,
    output logic [EW-1:0] errs
);
    rx_state_e     state_q, state_n;
    logic [W-1:0]  byte_q;
    logic [EW-1:0] err_q, err_n;
    logic          accept;

    assign accept = rx_valid && (state_q == RX_VACANT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_VACANT;
            byte_q  <= '0;
            err_q   <= '0;
        end else begin
            state_q <= state_n;
            err_q   <= err_n;
            if (accept) byte_q <= rx_data;
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            RX_VACANT: if (rx_valid) state_n = RX_LOADED;
            RX_LOADED: if (take) state_n = RX_VACANT;
            default:   state_n = RX_VACANT;
        endcase
        err_n = (take || accept) ? '0 : err_q;
        err_n = err_n | rx_err;
    end

    always_comb begin
        rx_byte = byte_q;
        avail   = (state_q == RX_LOADED);
        errs    = err_q;
    end
endmodule

// File: rtl/mdm_cfg_regs.sv
module mdm_cfg_regs
    import mdm_host_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_fmt,
    input  logic         wr_rate,
    input  logic         rd_mask,
    input  logic [W-1:0] wdata,
    output logic [1:0]   cfg_len,
    output logic [1:0]   cfg_par,
    output logic         cfg_stop2,
    output logic [W-1:0] rate_val,
    output logic [W-1:0] int_mask
);
    logic [W-1:0] fmt_q, rate_q, mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q  <= '0;
            rate_q <= '0;
            mask_q <= '0;
        end else begin
            if (wr_fmt)  fmt_q  <= wdata;
            if (wr_rate) rate_q <= wdata;
            if (rd_mask) mask_q <= rate_q;
        end
    end

    always_comb begin
        cfg_len   = fmt_q[3:2];
        cfg_par   = fmt_q[5:4];
        cfg_stop2 = fmt_q[6];
        rate_val  = rate_q;
        int_mask  = mask_q;
    end
endmodule

// File: rtl/mdm_host_regs.sv
module mdm_host_regs
    import mdm_host_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int AW = ADDR_W,
    parameter int EW = ERR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] host_addr,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [W-1:0]  host_wdata,
    output logic [W-1:0]  host_rdata,
    output logic [1:0]    cfg_len,
    output logic [1:0]    cfg_par,
    output logic          cfg_stop2,
    output logic [W-1:0]  rate_val,
    output logic [W-1:0]  int_mask,
    output logic [W-1:0]  tx_data,
    output logic          tx_valid,
    input  logic          tx_ready,
    input  logic          tx_done,
    input  logic          rx_valid,
    input  logic [W-1:0]  rx_data,
    input  logic [EW-1:0] rx_err
);
    localparam int PAD_W = W - 3 - EW;

    port_e         port;
    logic          tx_empty, rx_avail;
    logic [EW-1:0] rx_errs;
    logic [W-1:0]  rx_byte, status_w;

    assign port = port_e'(host_addr);

    mdm_cfg_regs #(.W(W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_fmt (host_wr && port == PORT_CTRL),
        .wr_rate(host_wr && port == PORT_RATE),
        .rd_mask(host_rd && port == PORT_MASK),
        .wdata(host_wdata),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
        .rate_val(rate_val), .int_mask(int_mask)
    );

    mdm_tx_ctrl #(.W(W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .load(host_wr && port == PORT_DATA), .load_data(host_wdata),
        .tx_ready(tx_ready), .tx_done(tx_done),
        .tx_data(tx_data), .tx_valid(tx_valid), .empty(tx_empty)
    );

    mdm_rx_ctrl #(.W(W), .EW(EW)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
        .take(host_rd && port == PORT_DATA),
        .rx_byte(rx_byte), .avail(rx_avail), .errs(rx_errs)
    );

    assign status_w = {{PAD_W{1'b0}}, rx_errs, tx_empty, rx_avail, tx_empty};

    always_comb begin
        host_rdata = '0;
        unique case (port)
            PORT_CTRL: host_rdata = status_w;
            PORT_DATA: host_rdata = rx_byte;
            PORT_RATE: host_rdata = '0;
            PORT_MASK: host_rdata = '0;
            default:   host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdm_host_regs_chk.sv
module mdm_host_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] host_addr,
    input logic       host_wr,
    input logic       host_rd,
    input logic [7:0] host_wdata,
    input logic [7:0] host_rdata,
    input logic [7:0] status_w,
    input logic [7:0] rx_byte,
    input logic [7:0] rate_val,
    input logic [7:0] int_mask,
    input logic [7:0] tx_data,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       rx_valid
);
    assert_tx_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 2'd1) |=> (tx_valid && tx_data == $past(host_wdata)
                                            && status_w[0] == 1'b0 && status_w[2] == 1'b0));

    assert_tx_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !(host_wr && host_addr == 2'd1)) |=> !tx_valid);

    assert_rx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && status_w[1] && !(host_rd && host_addr == 2'd1)) |=> $stable(rx_byte));

    assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 2'd1 && !rx_valid) |=> (status_w[1] == 1'b0));

    assert_mask_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 2'd3) |=> (int_mask == $past(rate_val)));

    assert_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_addr[1] |-> (host_rdata == 8'h00));

    assert_no_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rd && !host_wr) |=> ($stable(int_mask) && $stable(rate_val)));
endmodule

bind mdm_host_regs mdm_host_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .status_w(status_w), .rx_byte(rx_byte), .rate_val(rate_val),
    .int_mask(int_mask), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_valid(rx_valid)
);

// File: tb/mdm_host_regs_bench.sv
`timescale 1ns/1ps
module mdm_host_regs_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_addr = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0, host_rdata;
    logic [1:0] cfg_len, cfg_par;
    logic       cfg_stop2;
    logic [7:0] rate_val, int_mask, tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b0, tx_done = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic [2:0] rx_err = '0;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    mdm_host_regs u_mdm_host_regs (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
        .rate_val(rate_val), .int_mask(int_mask), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_done(tx_done),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err)
    );

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk); host_addr = a; host_rd = 1'b1; #1 d = host_rdata;
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic pulse_rx(logic [7:0] d);
        @(negedge clk); rx_data = d; rx_valid = 1'b1; @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd0, v);
        check("R1 status", v, 8'h00);
        check("R1 format", {3'b0, cfg_stop2, cfg_par, cfg_len}, 8'h00);
        check("R1 rate", rate_val, 8'h00);
        check("R1 mask", int_mask, 8'h00);
        check("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
    endtask

    task automatic t_format();
        wr(2'd0, 8'h4C);
        check("R2 len 8 bits", {6'b0, cfg_len}, 8'h03);
        check("R2 parity odd", {6'b0, cfg_par}, 8'h00);
        check("R2 two stop", {7'b0, cfg_stop2}, 8'h01);
        wr(2'd0, 8'h24);
        check("R2 len 6 bits", {6'b0, cfg_len}, 8'h01);
        check("R2 parity even", {6'b0, cfg_par}, 8'h02);
        check("R2 one stop", {7'b0, cfg_stop2}, 8'h00);
        wr(2'd0, 8'h18);
        check("R2 len 7/none", {4'b0, cfg_par, cfg_len}, 8'h06);
    endtask

    task automatic t_transmit();
        logic [7:0] v;
        pulse_done();
        rd(2'd0, v);
        check("R6 done sets empty (R3 bits 0,2)", v, 8'h05);
        wr(2'd1, 8'h5A);
        check("R4 tx_data", tx_data, 8'h5A);
        check("R4 tx_valid", {7'b0, tx_valid}, 8'h01);
        rd(2'd0, v);
        check("R4 empty flags cleared", v, 8'h00);
        wr(2'd1, 8'hA5);
        check("R5 overwrite data", tx_data, 8'hA5);
        check("R5 still valid", {7'b0, tx_valid}, 8'h01);
        pulse_done();
        rd(2'd0, v);
        check("R6 done ignored while held", v, 8'h00);
        @(negedge clk); tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
        check("R6 handoff drops valid", {7'b0, tx_valid}, 8'h00);
        pulse_done();
        rd(2'd0, v);
        check("R6 completion sets empty", v, 8'h05);
    endtask

    task automatic t_receive();
        logic [7:0] v;
        pulse_rx(8'h44);
        rd(2'd0, v);
        check("R7 avail set", v, 8'h07);
        pulse_rx(8'h55);
        rd(2'd1, v);
        check("R7 second byte ignored", v, 8'h44);
        rd(2'd0, v);
        check("R8 read clears avail", v, 8'h05);
        @(negedge clk); rx_err = 3'b101; @(negedge clk); rx_err = 3'b000;
        rd(2'd0, v);
        check("R8 parity+framing flags", v, 8'h2D);
        @(negedge clk); rx_err = 3'b010; @(negedge clk); rx_err = 3'b000;
        rd(2'd0, v);
        check("R8 overrun added", v, 8'h3D);
        pulse_rx(8'h66);
        rd(2'd0, v);
        check("R7 accept clears errors", v, 8'h07);
        @(negedge clk); rx_err = 3'b111; @(negedge clk); rx_err = 3'b000;
        rd(2'd1, v);
        check("R8 data read value", v, 8'h66);
        rd(2'd0, v);
        check("R8 read clears errors", v, 8'h05);
    endtask

    task automatic t_rate_mask();
        logic [7:0] v;
        wr(2'd2, 8'h20);
        check("R9 rate loaded", rate_val, 8'h20);
        check("R9 mask untouched by write", int_mask, 8'h00);
        @(negedge clk); host_addr = 2'd3;
        @(negedge clk); host_addr = 2'd1;
        @(negedge clk);
        check("R11 idle address no mask copy", int_mask, 8'h00);
        pulse_rx(8'h77);
        @(negedge clk); host_addr = 2'd1;
        @(negedge clk); host_addr = 2'd0;
        #1 check("R11 idle address keeps avail", host_rdata, 8'h07);
        rd(2'd1, v);
        rd(2'd2, v);
        check("R10 port 2 reads zero", v, 8'h00);
        rd(2'd3, v);
        check("R10 port 3 reads zero", v, 8'h00);
        check("R9 mask copied", int_mask, 8'h20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_format();
        t_transmit();
        t_receive();
        t_rate_mask();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule